// File: doc/BRIEF.md
# Chained Multiply-Add Digit Engine

This engine multiplies a big integer by one scalar word. The big integer arrives as a stream of digits, least significant digit first. For each digit, the engine forms the full double-width value digit × multiplier + carry. The lower half of that value is sent out as the result digit. The upper half is kept and becomes the carry for the next digit. No separate carry flag exists. The double-width value always has room for the largest possible operands, so the upper half alone carries everything over into the next position.

A transfer starts with a one-cycle start strobe. The start strobe samples the vector length, the scalar multiplier and the initial carry. The initial carry is normally zero. Digits are then taken one per accepted valid/ready beat. Each accepted beat gives exactly one result digit on the next cycle. After the last digit, a one-cycle done pulse appears and the final carry is presented. A length of zero finishes at once, and the carry output then equals the initial carry.

The controller is a three-state machine:
- `ST_IDLE` waits for start.
- `ST_RUN` accepts digits.
- `ST_DONE` raises done for one cycle.

Its transitions are:
- idle→run on start with a non-zero length.
- idle→done on start with a zero length.
- run→done when the last digit is accepted.
- done→idle unconditionally.

Top module: `mac_chain_engine`

## Requirements
- R1: After reset, `dig_ready_o`, `res_valid_o` and `done_o` are all 0.
- R2: For each accepted digit, `res_o` equals the low DW bits of digit × multiplier + carry. It is presented with `res_valid_o` = 1 in the cycle after acceptance.
- R3: The carry used for the first digit is `carry_init_i` sampled at start. The carry used for every later digit is the high DW bits of the previous digit's full value.
- R4: Digit × multiplier + carry never needs more than 2·DW bits, even with all three operands at their maximum value. With all operands all-ones, the result digit is 0 and the carry is all-ones.
- R5: The multiplier and initial carry are sampled only at start. Changing `mult_i` or `carry_init_i` during a transfer has no effect on its results.
- R6: Digits are accepted in arrival order, one per cycle at most. `dig_ready_o` is 1 throughout the run state. Cycles without `dig_valid_i` produce no result.
- R7: `done_o` pulses for exactly one cycle, in the same cycle as the last result digit. `carry_o` then equals the final high half and holds that value until the next start.
- R8: With a length of 0, `done_o` is 1 in the cycle after start, `carry_o` equals the initial carry, and no result or ready is produced.
- R9: A start strobe while a transfer is in progress is ignored. The transfer continues with its original length and multiplier.
- R10: `dig_valid_i` while idle is ignored: no result is produced and `dig_ready_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, honoured only when idle |
| len_i | input | LEN_W | Number of digits in the vector |
| mult_i | input | DW | Scalar multiplier |
| carry_init_i | input | DW | Carry into the first digit |
| dig_valid_i | input | 1 | Input digit valid |
| dig_i | input | DW | Input digit |
| dig_ready_o | output | 1 | Engine can accept a digit |
| res_valid_o | output | 1 | Result digit valid |
| res_o | output | DW | Result digit (low half) |
| done_o | output | 1 | One-cycle completion pulse |
| carry_o | output | DW | Final carry (high half) |

## Verification
The bench builds the engine with its default DW = 64 and LEN_W = 8. The 64-bit width reaches the extreme case where every operand is all-ones and the upper half saturates without spilling. The 8-bit length field allows zero-length and single-digit vectors next to multi-digit chains. Ripple through an all-ones digit, stalls between beats, and start or multiplier changes in mid-run are all driven at the real widths.

// File: rtl/mac_chain_pkg.sv
package mac_chain_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } eng_state_e;

endpackage

// File: rtl/mac_chain_ctrl.sv
module mac_chain_ctrl
    import mac_chain_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             dig_valid_i,
    output logic             load_o,
    output logic             accept_o,
    output logic             dig_ready_o,
    output logic             done_o
);

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    eng_state_e       state_q, state_d;
    logic [LEN_W-1:0] cnt_q;
    logic             last_beat;

    assign last_beat = accept_o && (cnt_q == ONE);

    // state register and remaining-digit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load_o)
                cnt_q <= len_i;
            else if (accept_o)
                cnt_q <= cnt_q - ONE;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = (len_i == '0) ? ST_DONE : ST_RUN;
            ST_RUN:  if (last_beat) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_o      = 1'b0;
        dig_ready_o = 1'b0;
        done_o      = 1'b0;
        unique case (state_q)
            ST_IDLE: load_o      = start_i;
            ST_RUN:  dig_ready_o = 1'b1;
            ST_DONE: done_o      = 1'b1;
            default: ;
        endcase
        accept_o = dig_ready_o && dig_valid_i;
    end

    // R8: zero length completes on the next cycle
    assert_zero_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && len_i == '0) |=> done_o);

    // R7: done follows acceptance of the final digit and lasts one cycle
    assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && cnt_q == ONE) |=> done_o);
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: start during a run does not reload the counter
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && start_i && !dig_valid_i) |=> $stable(cnt_q));

endmodule

// File: rtl/mac_chain_dp.sv
module mac_chain_dp #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          accept_i,
    input  logic [DW-1:0] mult_i,
    input  logic [DW-1:0] carry_init_i,
    input  logic [DW-1:0] dig_i,
    output logic          res_valid_o,
    output logic [DW-1:0] res_o,
    output logic [DW-1:0] carry_o
);

    localparam int PW = 2 * DW;

    logic [DW-1:0] mult_q;
    logic [DW-1:0] carry_q;
    logic [DW-1:0] res_q;
    logic          res_valid_q;
    logic [PW-1:0] prod_w;
    logic [PW:0]   sum_w;

    always_comb begin
        prod_w = PW'(dig_i) * PW'(mult_q);
        sum_w  = {1'b0, prod_w} + (PW + 1)'(carry_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mult_q      <= '0;
            carry_q     <= '0;
            res_q       <= '0;
            res_valid_q <= 1'b0;
        end else begin
            res_valid_q <= accept_i;
            if (load_i) begin
                mult_q  <= mult_i;
                carry_q <= carry_init_i;
            end else if (accept_i) begin
                res_q   <= sum_w[DW-1:0];
                carry_q <= sum_w[PW-1:DW];
            end
        end
    end

    assign res_o       = res_q;
    assign res_valid_o = res_valid_q;
    assign carry_o     = carry_q;

    // R4: the double-width value never spills past 2*DW bits
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |-> (sum_w[PW] == 1'b0));

    // R6: every result follows an accepted beat
    assert_result_follows_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> $past(accept_i));

    // R5 / R7: the multiplier and carry hold when nothing is loaded or accepted
    assert_mult_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(mult_q));
    assert_carry_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !accept_i) |=> $stable(carry_o));

endmodule

// File: rtl/mac_chain_engine.sv
module mac_chain_engine #(
    parameter int DW    = 64,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [DW-1:0]    mult_i,
    input  logic [DW-1:0]    carry_init_i,
    input  logic             dig_valid_i,
    input  logic [DW-1:0]    dig_i,
    output logic             dig_ready_o,
    output logic             res_valid_o,
    output logic [DW-1:0]    res_o,
    output logic             done_o,
    output logic [DW-1:0]    carry_o
);

    logic load_w;
    logic accept_w;

    mac_chain_ctrl #(
        .LEN_W(LEN_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .len_i      (len_i),
        .dig_valid_i(dig_valid_i),
        .load_o     (load_w),
        .accept_o   (accept_w),
        .dig_ready_o(dig_ready_o),
        .done_o     (done_o)
    );

    mac_chain_dp #(
        .DW(DW)
    ) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_w),
        .accept_i    (accept_w),
        .mult_i      (mult_i),
        .carry_init_i(carry_init_i),
        .dig_i       (dig_i),
        .res_valid_o (res_valid_o),
        .res_o       (res_o),
        .carry_o     (carry_o)
    );

    // R10: no result can appear unless a digit was offered while ready
    assert_idle_valid_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> $past(dig_ready_o && dig_valid_i));

    // R8: zero-length completion emits no result
    assert_zero_len_no_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !$past(dig_ready_o)) |-> !res_valid_o);

endmodule

// File: tb/mac_chain_engine_bench.sv
module mac_chain_engine_bench;

    localparam int DW    = 64;
    localparam int LEN_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [LEN_W-1:0] len_i = '0;
    logic [DW-1:0]    mult_i = '0;
    logic [DW-1:0]    carry_init_i = '0;
    logic             dig_valid_i = 1'b0;
    logic [DW-1:0]    dig_i = '0;
    logic             dig_ready_o;
    logic             res_valid_o;
    logic [DW-1:0]    res_o;
    logic             done_o;
    logic [DW-1:0]    carry_o;

    int n_checks = 0;
    int n_errors = 0;
    logic [DW-1:0] dv [16];

    always #10 clk = ~clk;

    mac_chain_engine #(.DW(DW), .LEN_W(LEN_W)) u_mac_chain_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .mult_i(mult_i), .carry_init_i(carry_init_i),
        .dig_valid_i(dig_valid_i), .dig_i(dig_i), .dig_ready_o(dig_ready_o),
        .res_valid_o(res_valid_o), .res_o(res_o), .done_o(done_o), .carry_o(carry_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    // R1: reset state
    task automatic t_reset();
        @(negedge clk);
        chk(dig_ready_o == 1'b0, "R1", "ready after reset", DW'(dig_ready_o), 0);
        chk(res_valid_o == 1'b0, "R1", "res_valid after reset", DW'(res_valid_o), 0);
        chk(done_o == 1'b0, "R1", "done after reset", DW'(done_o), 0);
    endtask

    // R10: valid while idle has no effect
    task automatic t_idle_valid();
        dig_valid_i = 1'b1;
        dig_i = 64'h55;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(res_valid_o == 1'b0, "R10", "result from idle valid", DW'(res_valid_o), 0);
            chk(dig_ready_o == 1'b0, "R10", "ready while idle", DW'(dig_ready_o), 0);
        end
        dig_valid_i = 1'b0;
    endtask

    // R2 R3 R5 R6 R7 R8 R9: run one vector through the engine
    task automatic t_vec(input int n, input logic [DW-1:0] m,
                         input logic [DW-1:0] c0, input bit gaps);
        logic [DW-1:0]   cy;
        logic [2*DW-1:0] full;
        @(negedge clk);
        start_i = 1'b1;
        len_i = LEN_W'(n);
        mult_i = m;
        carry_init_i = c0;
        @(negedge clk);
        start_i = 1'b0;
        mult_i = ~m;
        carry_init_i = ~c0;
        if (n == 0) begin
            chk(done_o == 1'b1, "R8", "done after zero-length start", DW'(done_o), 1);
            chk(carry_o == c0, "R8", "carry for zero length", carry_o, c0);
            chk(res_valid_o == 1'b0, "R8", "result on zero length", DW'(res_valid_o), 0);
            chk(dig_ready_o == 1'b0, "R8", "ready on zero length", DW'(dig_ready_o), 0);
            @(negedge clk);
            chk(done_o == 1'b0, "R7", "done width", DW'(done_o), 0);
            return;
        end
        chk(dig_ready_o == 1'b1, "R6", "ready in run", DW'(dig_ready_o), 1);
        cy = c0;
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 2 == 1)) begin
                dig_valid_i = 1'b0;
                start_i = 1'b1;
                len_i = 8'd1;
                @(negedge clk);
                start_i = 1'b0;
                chk(res_valid_o == 1'b0, "R6", "result during stall", DW'(res_valid_o), 0);
                chk(dig_ready_o == 1'b1, "R9", "run continues after start", DW'(dig_ready_o), 1);
            end
            dig_valid_i = 1'b1;
            dig_i = dv[i];
            @(negedge clk);
            full = (2*DW)'(dv[i]) * (2*DW)'(m) + (2*DW)'(cy);
            chk(res_valid_o == 1'b1, "R6", "result valid", DW'(res_valid_o), 1);
            chk(res_o == full[DW-1:0], "R2", "result digit", res_o, full[DW-1:0]);
            cy = full[2*DW-1:DW];
            if (i == n - 1) begin
                chk(done_o == 1'b1, "R7", "done with last result", DW'(done_o), 1);
                chk(carry_o == cy, "R3", "final carry", carry_o, cy);
            end else begin
                chk(done_o == 1'b0, "R7", "early done", DW'(done_o), 0);
            end
        end
        dig_valid_i = 1'b0;
        @(negedge clk);
        chk(done_o == 1'b0, "R7", "done width", DW'(done_o), 0);
        chk(carry_o == cy, "R7", "carry held", carry_o, cy);
        chk(dig_ready_o == 1'b0, "R6", "ready after run", DW'(dig_ready_o), 0);
    endtask

    // R4: all-ones operands
    task automatic t_all_ones();
        for (int i = 0; i < 4; i++) dv[i] = '1;
        t_vec(4, '1, '1, 1'b0);
        chk(carry_o == '1, "R4", "saturated carry", carry_o, '1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset();
        t_idle_valid();
        dv[0] = 64'd5; dv[1] = 64'd7; dv[2] = '1;
        t_vec(3, 64'd3, 64'd0, 1'b0);
        t_all_ones();
        t_vec(0, 64'd9, 64'hDEAD, 1'b0);
        dv[0] = 64'h0123_4567_89AB_CDEF; dv[1] = 64'hFEDC_BA98_7654_3210;
        dv[2] = '0; dv[3] = 64'h8000_0000_0000_0000; dv[4] = 64'h1;
        t_vec(5, 64'h1234_5678_9ABC_DEF1, 64'h42, 1'b1);
        dv[0] = 64'hAAAA;
        t_vec(1, 64'd0, 64'd7, 1'b0);
        summary();
    end

endmodule